// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI controller from the core clock. Software writes an 8-bit prescale setting into the controller's configuration register. The block decodes that setting into a divide ratio and runs a half-period counter while the shift engine reports an exchange in progress. Each half period ends with a one-cycle toggle strobe, which paces the shift engine, and with an inversion of the serial clock output. When no exchange runs, the serial clock rests at the idle level chosen by the clock polarity input.

A parameter selects one of two encodings. The narrow encoding gives only even ratios from 4 to 30, stored with an offset of 16 in half-ratio units. The wide encoding multiplies a 4-bit linear factor by a power of two whose 3-bit exponent is split around the word-size bit of the configuration register. Choosing a prescale value for a wanted frequency is left to software.

Top module: `spi_sck_prescaler`

## Requirements
- R1: Narrow encoding: with field F = cfg[4:0] and F >= 18, the divide ratio is 2*(F-16), so F=19 gives 6 and F=31 gives 30.
- R2: Narrow encoding: any F below 18 (including 16 and 17, which would give 0 or 2) yields a ratio of 4.
- R3: Wide encoding: the ratio is L*2^E with L = cfg[3:0] and E = {cfg[7], cfg[6], cfg[4]} (cfg[7] the MSB), so cfg=0xDF gives the largest ratio, 1920.
- R4: Wide encoding: an L value below 4 is treated as 4, so the ratio is never below 4.
- R5: cfg[5] (the word-size bit) never affects the ratio; in the narrow encoding cfg[7:5] are also ignored.
- R6: While busy, sck inverts after every half period and sck_tgl is high for exactly the cycle in which the new sck level appears; a half period lasts ceil(ratio/2) cycles while sck is high and floor(ratio/2) cycles while sck is low.
- R7: The ratio is captured on every clock edge at which busy is low; a change of cfg while busy is high has no effect until busy has been low for one edge.
- R8: On the edge after reset or after any edge with busy low, sck equals cpol and sck_tgl is low; cpol changes during busy do not move sck.
- R9: Each busy period starts a fresh count: the first inversion comes floor(ratio/2) or ceil(ratio/2) edges (by the idle level) after the first edge with busy high, even if the previous period stopped mid half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psc_cfg | input | 8 | Prescale bits of the configuration register |
| cpol | input | 1 | Clock polarity: idle level of sck |
| xfer_busy | input | 1 | High while the shift engine runs an exchange |
| sck | output | 1 | Serial clock |
| sck_tgl | output | 1 | One-cycle strobe at each sck inversion |

## Verification
Two things can land on the same edge: a new prescale value arriving and the counter reaching the end of a half period, or the end of an exchange coinciding with a toggle. The bench changes cfg and cpol in the middle of busy windows, including at cycles where a toggle is due, and drops busy for a single cycle mid half-period before restarting. A behavioural model using integer counts for both encodings predicts sck and sck_tgl every cycle. Any disagreement is reported against the requirement under test at the time.

// File: rtl/spi_psc_pkg.sv
// Shared encoding choice and widths for the SPI clock prescaler.
// Assumes an 8-bit prescale slice of the configuration register.
package spi_psc_pkg;
    typedef enum logic {
        ENC_NARROW = 1'b0,
        ENC_WIDE   = 1'b1
    } psc_enc_e;

    localparam int CFG_W     = 8;
    localparam int LIN_W     = 4;
    localparam int EXP_W     = 3;
    localparam int RATIO_W   = LIN_W + (1 << EXP_W) - 1;
    localparam int MIN_RATIO = 4;
    localparam int NAR_W     = 5;
    localparam int NAR_BASE  = 16;
endpackage

// File: rtl/spi_psc_decode.sv
// Turns the prescale setting into a divide ratio (pure combinational).
// Assumes the word-size bit sits at LIN_W+1 and is never part of the setting.
module spi_psc_decode
    import spi_psc_pkg::*;
#(
    parameter psc_enc_e ENC = ENC_WIDE
) (
    input  logic [CFG_W-1:0]   cfg,
    output logic [RATIO_W-1:0] ratio
);
    generate
        if (ENC == ENC_NARROW) begin : g_narrow
            logic [NAR_W-1:0]       fld;
            logic                   cfg_unused;
            assign fld        = cfg[NAR_W-1:0];
            assign cfg_unused = ^cfg[CFG_W-1:NAR_W];

            // Offset field to even ratio, clamped at the minimum.
            always_comb begin
                if (fld >= NAR_W'(NAR_BASE + MIN_RATIO/2))
                    ratio = RATIO_W'(fld - NAR_W'(NAR_BASE)) << 1;
                else
                    ratio = RATIO_W'(MIN_RATIO);
            end
        end else begin : g_wide
            logic [LIN_W-1:0] lin;
            logic [LIN_W-1:0] lin_eff;
            logic [EXP_W-1:0] expo;
            logic             cfg_unused;
            assign lin        = cfg[LIN_W-1:0];
            assign expo       = {cfg[LIN_W+EXP_W:LIN_W+2], cfg[LIN_W]};
            assign cfg_unused = cfg[LIN_W+1];

            // Linear factor floored at the minimum, then scaled by 2^expo.
            assign lin_eff = (lin < LIN_W'(MIN_RATIO)) ? LIN_W'(MIN_RATIO) : lin;
            assign ratio   = RATIO_W'(lin_eff) << expo;
        end
    endgenerate
endmodule

// File: rtl/spi_psc_core.sv
// Half-period counter producing sck and its toggle strobe.
// Assumes ratio >= 4 and constant while busy is high.
module spi_psc_core
    import spi_psc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               busy,
    input  logic               cpol,
    output logic               sck,
    output logic               tgl
);
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] half_hi;
    logic [RATIO_W-1:0] half_lo;
    logic [RATIO_W-1:0] lim;

    // High half gets the extra cycle of an odd ratio.
    assign half_hi = (ratio + RATIO_W'(1)) >> 1;
    assign half_lo = ratio >> 1;
    assign lim     = sck ? half_hi : half_lo;

    // Count core cycles; invert sck at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            cnt <= '0;
            sck <= cpol;
            tgl <= 1'b0;
        end else if (cnt == lim - RATIO_W'(1)) begin
            cnt <= '0;
            sck <= ~sck;
            tgl <= 1'b1;
        end else begin
            cnt <= cnt + RATIO_W'(1);
            tgl <= 1'b0;
        end
    end

    a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (sck == $past(cpol)) && !tgl);
    a_r6_strobe_flips: assert property (@(posedge clk) disable iff (!rst_n)
        tgl |-> sck != $past(sck));
    a_r6_flip_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && sck != $past(sck)) |-> tgl);
    a_r6_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tgl |=> !tgl);
endmodule

// File: rtl/spi_sck_prescaler.sv
// SPI serial clock prescaler: captures the decoded ratio between exchanges
// and drives sck plus a half-period strobe. Assumes busy comes from the
// shift engine in the same clock domain.
module spi_sck_prescaler
    import spi_psc_pkg::*;
#(
    parameter psc_enc_e ENC = ENC_WIDE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] psc_cfg,
    input  logic             cpol,
    input  logic             xfer_busy,
    output logic             sck,
    output logic             sck_tgl
);
    localparam logic [RATIO_W-1:0] MAX_RATIO =
        RATIO_W'(((1 << LIN_W) - 1) << ((1 << EXP_W) - 1));

    logic [RATIO_W-1:0] ratio_d;
    logic [RATIO_W-1:0] ratio_q;

    spi_psc_decode #(.ENC(ENC)) u_decode (
        .cfg   (psc_cfg),
        .ratio (ratio_d)
    );

    // Capture the ratio only outside an exchange.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ratio_q <= RATIO_W'(MIN_RATIO);
        else if (!xfer_busy)
            ratio_q <= ratio_d;
    end

    spi_psc_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .ratio (ratio_q),
        .busy  (xfer_busy),
        .cpol  (cpol),
        .sck   (sck),
        .tgl   (sck_tgl)
    );

    a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_busy) |-> $stable(ratio_q));
    a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_q >= RATIO_W'(MIN_RATIO));
    a_r3_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_q <= MAX_RATIO);
endmodule

// File: tb/spi_sck_prescaler_bench.sv
`timescale 1ns/100ps
module spi_sck_prescaler_bench;
    import spi_psc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg = 8'h00;
    logic       cpol = 1'b0;
    logic       busy = 1'b0;
    logic       sck_w [2];
    logic       tgl_w [2];

    int   total = 0;
    int   bad = 0;
    int   cycles = 0;
    bit   done = 0;
    string cur_req = "R8";

    int   m_ratio [2];
    int   m_cnt [2];
    logic m_sck [2];
    logic m_tgl [2];

    always #2.5 clk = ~clk;

    spi_sck_prescaler #(.ENC(ENC_NARROW)) u_spi_sck_prescaler_nar (
        .clk(clk), .rst_n(rst_n), .psc_cfg(cfg), .cpol(cpol),
        .xfer_busy(busy), .sck(sck_w[0]), .sck_tgl(tgl_w[0]));

    spi_sck_prescaler u_spi_sck_prescaler (
        .clk(clk), .rst_n(rst_n), .psc_cfg(cfg), .cpol(cpol),
        .xfer_busy(busy), .sck(sck_w[1]), .sck_tgl(tgl_w[1]));

    // Ratio expected from the requirements (R1..R5).
    function automatic int exp_ratio(int enc, logic [7:0] c);
        int f, lin, e;
        if (enc == 0) begin
            f = int'(c[4:0]);
            return (f >= 18) ? 2 * (f - 16) : 4;
        end
        lin = int'(c[3:0]);
        if (lin < 4) lin = 4;
        e = 4 * int'(c[7]) + 2 * int'(c[6]) + int'(c[4]);
        return lin << e;
    endfunction

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n || !busy) begin
                m_sck[i] = cpol;
                m_tgl[i] = 1'b0;
                m_cnt[i] = 0;
                m_ratio[i] = !rst_n ? 4 : exp_ratio(i, cfg);
            end else begin
                int half;
                half = m_sck[i] ? (m_ratio[i] + 1) / 2 : m_ratio[i] / 2;
                m_cnt[i]++;
                if (m_cnt[i] == half) begin
                    m_sck[i] = ~m_sck[i];
                    m_tgl[i] = 1'b1;
                    m_cnt[i] = 0;
                end else begin
                    m_tgl[i] = 1'b0;
                end
            end
        end
        cycles++;
    end

    // Compare on every falling edge once out of reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 2; i++) begin
                total++;
                if (sck_w[i] !== m_sck[i] || tgl_w[i] !== m_tgl[i]) begin
                    bad++;
                    $display("FAIL %s enc=%0d t=%0t sck=%b exp=%b tgl=%b exp=%b",
                             cur_req, i, $time, sck_w[i], m_sck[i], tgl_w[i], m_tgl[i]);
                end
            end
        end
    end

    task automatic check(string req, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // One exchange window with a given setting.
    task automatic burst(string req, logic [7:0] c, logic pol, int n);
        cur_req = req;
        cfg = c;
        cpol = pol;
        cyc(3);
        busy = 1'b1;
        cyc(n);
        busy = 1'b0;
        cyc(3);
    endtask

    // Watchdog.
    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int n0, n1;
        // R8: reset state follows cpol.
        cpol = 1'b1;
        cyc(4);
        check("R8", int'(sck_w[0]), 1);
        check("R8", int'(sck_w[1]), 1);
        check("R8", int'(tgl_w[1]), 0);
        cpol = 1'b0;
        cyc(1);
        rst_n = 1'b1;
        cyc(2);

        burst("R1", 8'h13, 1'b0, 40);
        burst("R1", 8'h1F, 1'b0, 80);
        burst("R1", 8'h15, 1'b1, 40);
        burst("R2", 8'h10, 1'b0, 30);
        burst("R2", 8'h11, 1'b1, 30);
        burst("R3", 8'h47, 1'b0, 100);
        burst("R3", 8'h07, 1'b1, 60);
        burst("R3", 8'hDF, 1'b0, 4000);
        burst("R4", 8'h02, 1'b0, 30);
        burst("R4", 8'h00, 1'b1, 30);
        burst("R5", 8'h27, 1'b0, 60);
        burst("R5", 8'hE3, 1'b0, 60);

        // R6: odd wide ratio 5 (narrow reads 4), count strobes over 50 edges.
        cur_req = "R6";
        cfg = 8'h05;
        cpol = 1'b0;
        cyc(3);
        busy = 1'b1;
        n0 = 0;
        n1 = 0;
        for (int k = 0; k < 50; k++) begin
            cyc(1);
            n0 += int'(tgl_w[0]);
            n1 += int'(tgl_w[1]);
        end
        busy = 1'b0;
        check("R6", n1, 20);
        check("R6", n0, 25);
        cyc(3);

        // R7: setting changed mid-exchange must wait for idle.
        cur_req = "R7";
        cfg = 8'h03;
        cyc(3);
        busy = 1'b1;
        cyc(7);
        cfg = 8'h1F;
        cyc(40);
        busy = 1'b0;
        cyc(1);
        busy = 1'b1;
        cyc(70);
        busy = 1'b0;
        cyc(3);

        // R8: cpol moved during an exchange, then idle.
        cur_req = "R8";
        cfg = 8'h16;
        cyc(3);
        busy = 1'b1;
        cyc(9);
        cpol = 1'b1;
        cyc(20);
        busy = 1'b0;
        cyc(2);
        check("R8", int'(sck_w[1]), 1);
        check("R8", int'(tgl_w[0]), 0);

        // R9: stop mid half-period and restart after one idle edge.
        cur_req = "R9";
        cfg = 8'h09;
        cpol = 1'b0;
        cyc(3);
        busy = 1'b1;
        cyc(6);
        busy = 1'b0;
        cyc(1);
        busy = 1'b1;
        cyc(3);
        check("R9", int'(sck_w[1]), 0);
        cyc(1);
        check("R9", int'(sck_w[1]), 1);
        cyc(30);
        busy = 1'b0;
        cyc(3);

        finish_run();
    end
endmodule